// File: doc/BRIEF.md
# CAN Bit-Level Error Detector

This block sits beside the protocol controller of one CAN node and looks at every bit at its sample point. For each bit it receives the level the node drove, the level it read back from the bus, a code that says which part of the frame the bit belongs to, and whether the node currently owns the frame as transmitter. From these inputs it raises a one-clock strobe for each of four fault kinds: bit, stuff, form and acknowledge. On the following sample point it raises a one-clock request telling the controller to begin an error flag.

Bit monitoring honours the protocol's exemptions. A node that loses arbitration is not in error. A transmitter that sees receivers pull the ACK slot dominant is not in error. A node emitting a passive, recessive error flag that sees another node's dominant flag is not in error. Stuff checking runs only over the stuffed part of a frame. It starts again at each start-of-frame and flags the sixth bit in a row at the same level.

Top module: `can_error_detector`

## Requirements
- R1: When a bit is sampled (`bit_en`=1) and the node is driving the bus (`is_tx`=1 in any frame field code 1..8, or any node in the error-flag field code 9), a difference between `tx_bit` and `rx_bit` sets `bit_err` high for exactly the one clock after that sample, unless R2, R3 or R4 exempts it. Level 1 is recessive and level 0 is dominant.
- R2: In the arbitration field (code 2), driving recessive and reading dominant does not set `bit_err`.
- R3: In the ACK slot (code 6), driving recessive and reading dominant sets neither `bit_err` nor `ack_err`.
- R4: In the error-flag field (code 9) with `passive_flag`=1, driving recessive and reading dominant does not set `bit_err`. With `passive_flag`=0, driving dominant and reading recessive does set it.
- R5: Start-of-frame (code 1) restarts the equal-level run at length 1 with its own level. In the stuffed fields (arbitration 2, control/data 3, CRC sequence 4), a bit equal to the previous stuffed bit extends the run, and a different bit restarts it at 1. The sixth equal bit in a row sets `stuff_err` and restarts the run at 1. Bits in any other field neither extend nor clear the run.
- R6: When `is_tx`=1, reading recessive in the ACK slot (code 6) sets `ack_err`. A node with `is_tx`=0 never sets `ack_err`.
- R7: Reading dominant in the CRC delimiter (5), the ACK delimiter (7) or end-of-frame (8) sets `form_err`. Reading recessive there does not.
- R8: If any of the four error strobes was set by a sample, `flag_req` is high for the one clock after the next sample, however many clocks without `bit_en` lie between the two samples.
- R9: After reset, and in every clock that does not follow a sample, all five outputs are low. Idle (code 0) and unused codes 10..15 raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one clock at each bit sample point |
| field | input | 4 | Frame field code of the current bit (see R1..R9) |
| tx_bit | input | 1 | Level the node drives in this bit (1 recessive) |
| rx_bit | input | 1 | Level sampled from the bus in this bit |
| is_tx | input | 1 | Node is transmitter of the current frame |
| passive_flag | input | 1 | Node's error flag is the passive (recessive) kind |
| bit_err | output | 1 | Bit error strobe |
| stuff_err | output | 1 | Stuff error strobe |
| form_err | output | 1 | Form error strobe |
| ack_err | output | 1 | Acknowledge error strobe |
| flag_req | output | 1 | Start an error flag at this bit |

## Verification
The stuff error is the hardest case to reach. It needs six equal samples in a row within the stuffed fields, optionally split across field changes, and random bus levels seldom produce that. Directed sequences therefore walk a start-of-frame followed by five equal bits, with a bit from a non-stuffed field placed in the middle of one run. The random phase also repeats the previous bus level three times in four, so that long runs and the R8 carry-over across gaps without samples occur often.

// File: rtl/can_errdet_pkg.sv
package can_errdet_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        FLD_IDLE     = 4'd0,
        FLD_SOF      = 4'd1,
        FLD_ARB      = 4'd2,
        FLD_CTRL     = 4'd3,
        FLD_CRC_SEQ  = 4'd4,
        FLD_CRC_DLM  = 4'd5,
        FLD_ACK_SLOT = 4'd6,
        FLD_ACK_DLM  = 4'd7,
        FLD_EOF      = 4'd8,
        FLD_ERR_FLAG = 4'd9
    } field_e;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    typedef struct packed {
        logic bit_e;
        logic stuff_e;
        logic form_e;
        logic ack_e;
    } err_vec_t;

    function automatic logic in_stuff_window(input logic [FIELD_W-1:0] f);
        return (f == FLD_ARB) || (f == FLD_CTRL) || (f == FLD_CRC_SEQ);
    endfunction

    function automatic logic is_fixed_form(input logic [FIELD_W-1:0] f);
        return (f == FLD_CRC_DLM) || (f == FLD_ACK_DLM) || (f == FLD_EOF);
    endfunction

    function automatic logic in_frame(input logic [FIELD_W-1:0] f);
        return (f >= FLD_SOF) && (f <= FLD_EOF);
    endfunction

endpackage

// File: rtl/can_bit_monitor.sv
module can_bit_monitor
    import can_errdet_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    input  logic               tx_bit_i,
    input  logic               rx_bit_i,
    input  logic               is_tx_i,
    input  logic               passive_i,
    output logic               bit_err_o
);
    logic driving;
    logic rec_lost;
    logic exempt;

    always_comb begin
        driving  = (is_tx_i && in_frame(field_i)) || (field_i == FLD_ERR_FLAG);
        rec_lost = (tx_bit_i == LVL_REC) && (rx_bit_i == LVL_DOM);
        exempt   = rec_lost && ((field_i == FLD_ARB) ||
                                (field_i == FLD_ACK_SLOT) ||
                                ((field_i == FLD_ERR_FLAG) && passive_i));
        bit_err_o = driving && (tx_bit_i != rx_bit_i) && !exempt;
    end
endmodule

// File: rtl/can_stuff_checker.sv
module can_stuff_checker
    import can_errdet_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               rx_bit_i,
    output logic               stuff_err_o
);
    localparam int CNT_W = $clog2(RUN_LIMIT + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LIMIT);
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    logic             last_q, last_d;
    logic [CNT_W-1:0] run_q, run_d;

    always_comb begin
        stuff_err_o = 1'b0;
        last_d      = last_q;
        run_d       = run_q;
        if (en_i) begin
            if (field_i == FLD_SOF) begin
                last_d = rx_bit_i;
                run_d  = RUN_ONE;
            end else if (in_stuff_window(field_i)) begin
                if (rx_bit_i != last_q) begin
                    last_d = rx_bit_i;
                    run_d  = RUN_ONE;
                end else if (run_q >= RUN_MAX) begin
                    stuff_err_o = 1'b1;
                    run_d       = RUN_ONE;
                end else begin
                    run_d = run_q + RUN_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= LVL_REC;
            run_q  <= '0;
        end else begin
            last_q <= last_d;
            run_q  <= run_d;
        end
    end
endmodule

// File: rtl/can_frame_checks.sv
module can_frame_checks
    import can_errdet_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    input  logic               rx_bit_i,
    input  logic               is_tx_i,
    output logic               form_err_o,
    output logic               ack_err_o
);
    always_comb begin
        form_err_o = is_fixed_form(field_i) && (rx_bit_i == LVL_DOM);
        ack_err_o  = is_tx_i && (field_i == FLD_ACK_SLOT) && (rx_bit_i == LVL_REC);
    end
endmodule

// File: rtl/can_error_detector.sv
module can_error_detector
    import can_errdet_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic [FIELD_W-1:0] field,
    input  logic               tx_bit,
    input  logic               rx_bit,
    input  logic               is_tx,
    input  logic               passive_flag,
    output logic               bit_err,
    output logic               stuff_err,
    output logic               form_err,
    output logic               ack_err,
    output logic               flag_req
);
    err_vec_t det;
    err_vec_t err_q;
    logic     pend_q;
    logic     flag_q;

    can_bit_monitor u_bitmon (
        .field_i   (field),
        .tx_bit_i  (tx_bit),
        .rx_bit_i  (rx_bit),
        .is_tx_i   (is_tx),
        .passive_i (passive_flag),
        .bit_err_o (det.bit_e)
    );

    can_stuff_checker #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
        .clk         (clk),
        .rst         (rst),
        .en_i        (bit_en),
        .field_i     (field),
        .rx_bit_i    (rx_bit),
        .stuff_err_o (det.stuff_e)
    );

    can_frame_checks u_frame (
        .field_i    (field),
        .rx_bit_i   (rx_bit),
        .is_tx_i    (is_tx),
        .form_err_o (det.form_e),
        .ack_err_o  (det.ack_e)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            err_q  <= '0;
            flag_q <= 1'b0;
            if (bit_en) begin
                err_q  <= det;
                flag_q <= pend_q;
                pend_q <= |det;
            end
        end
    end

    assign bit_err   = err_q.bit_e;
    assign stuff_err = err_q.stuff_e;
    assign form_err  = err_q.form_e;
    assign ack_err   = err_q.ack_e;
    assign flag_req  = flag_q;
endmodule

// File: rtl/can_errdet_chk.sv
module can_errdet_chk
    import can_errdet_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bit_en,
    input logic [FIELD_W-1:0] field,
    input logic               tx_bit,
    input logic               rx_bit,
    input logic               is_tx,
    input logic               passive_flag,
    input logic               bit_err,
    input logic               stuff_err,
    input logic               form_err,
    input logic               ack_err,
    input logic               flag_req
);
    a_r9_quiet_without_sample: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !(bit_err || stuff_err || form_err || ack_err || flag_req));

    a_r1_mismatch_in_data: assert property (@(posedge clk) disable iff (rst)
        (bit_en && is_tx && field == FLD_CTRL && tx_bit != rx_bit) |=> bit_err);

    a_r2_arbitration_loss: assert property (@(posedge clk) disable iff (rst)
        (bit_en && field == FLD_ARB && tx_bit && !rx_bit) |=> !bit_err);

    a_r4_passive_flag: assert property (@(posedge clk) disable iff (rst)
        (bit_en && field == FLD_ERR_FLAG && passive_flag && tx_bit && !rx_bit) |=> !bit_err);

    a_r6_no_ack: assert property (@(posedge clk) disable iff (rst)
        (bit_en && is_tx && field == FLD_ACK_SLOT && rx_bit) |=> ack_err);

    a_r7_fixed_form: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !rx_bit && (field == FLD_CRC_DLM || field == FLD_ACK_DLM || field == FLD_EOF))
        |=> form_err);

    a_r8_flag_follows: assert property (@(posedge clk) disable iff (rst)
        ((bit_err || stuff_err || form_err || ack_err) && bit_en) |=> flag_req);
endmodule

bind can_error_detector can_errdet_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .field        (field),
    .tx_bit       (tx_bit),
    .rx_bit       (rx_bit),
    .is_tx        (is_tx),
    .passive_flag (passive_flag),
    .bit_err      (bit_err),
    .stuff_err    (stuff_err),
    .form_err     (form_err),
    .ack_err      (ack_err),
    .flag_req     (flag_req)
);

// File: tb/sim_can_error_detector.sv
module sim_can_error_detector;
    localparam int CLK_PERIOD = 10;
    localparam int RUNS = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [3:0] field = 4'd0;
    logic       tx_bit = 1'b1;
    logic       rx_bit = 1'b1;
    logic       is_tx = 1'b0;
    logic       passive_flag = 1'b0;
    logic       bit_err, stuff_err, form_err, ack_err, flag_req;

    int checks = 0;
    int errors = 0;

    logic m_last = 1'b1;
    int   m_run  = 0;
    logic m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_error_detector u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .field(field),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .is_tx(is_tx), .passive_flag(passive_flag),
        .bit_err(bit_err), .stuff_err(stuff_err), .form_err(form_err),
        .ack_err(ack_err), .flag_req(flag_req)
    );

    function automatic logic want_bit(logic [3:0] f, logic t, logic r, logic tx, logic pas);
        logic drv, ex;
        drv = (tx && f >= 4'd1 && f <= 4'd8) || f == 4'd9;
        ex  = t && !r && (f == 4'd2 || f == 4'd6 || (f == 4'd9 && pas));
        return drv && (t != r) && !ex;
    endfunction

    function automatic logic want_form(logic [3:0] f, logic r);
        return !r && (f == 4'd5 || f == 4'd7 || f == 4'd8);
    endfunction

    function automatic logic want_ack(logic [3:0] f, logic r, logic tx);
        return tx && f == 4'd6 && r;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(logic en, logic [3:0] f, logic t, logic r, logic tx, logic pas, string tag);
        logic eb, es, ef, ea, eq;
        @(negedge clk);
        bit_en = en; field = f; tx_bit = t; rx_bit = r; is_tx = tx; passive_flag = pas;
        eb = 0; es = 0; ef = 0; ea = 0; eq = 0;
        if (en) begin
            eb = want_bit(f, t, r, tx, pas);
            ef = want_form(f, r);
            ea = want_ack(f, r, tx);
            if (f == 4'd1) begin
                m_last = r; m_run = 1;
            end else if (f >= 4'd2 && f <= 4'd4) begin
                if (r != m_last) begin
                    m_last = r; m_run = 1;
                end else if (m_run >= RUNS) begin
                    es = 1; m_run = 1;
                end else begin
                    m_run++;
                end
            end
            eq = m_pend;
            m_pend = eb | es | ef | ea;
        end
        @(posedge clk);
        #1;
        chk(tag, "R1 bit_err", bit_err, eb);
        chk(tag, "R5 stuff_err", stuff_err, es);
        chk(tag, "R7 form_err", form_err, ef);
        chk(tag, "R6 ack_err", ack_err, ea);
        chk(tag, "R8 flag_req", flag_req, eq);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL [watchdog] run did not complete");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset bit_err", bit_err, 1'b0);
        chk("R9", "reset stuff_err", stuff_err, 1'b0);
        chk("R9", "reset form_err", form_err, 1'b0);
        chk("R9", "reset ack_err", ack_err, 1'b0);
        chk("R9", "reset flag_req", flag_req, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1 plain mismatch, R2 arbitration exemption
        step(1, 4'd3, 0, 1, 1, 0, "R1");
        step(1, 4'd2, 1, 0, 1, 0, "R2");
        step(1, 4'd2, 0, 1, 1, 0, "R1");
        // R3 ACK slot exemption, R6 missing acknowledge
        step(1, 4'd6, 1, 0, 1, 0, "R3");
        step(1, 4'd6, 1, 1, 1, 0, "R6");
        step(1, 4'd6, 1, 1, 0, 0, "R6");
        // R4 passive and active error flags
        step(1, 4'd9, 1, 0, 0, 1, "R4");
        step(1, 4'd9, 0, 1, 0, 0, "R4");
        // R7 fixed-form fields
        step(1, 4'd5, 1, 0, 0, 0, "R7");
        step(1, 4'd7, 1, 1, 0, 0, "R7");
        step(1, 4'd7, 1, 0, 0, 0, "R7");
        step(1, 4'd8, 1, 0, 0, 0, "R7");
        // R8 pending request survives gaps without samples
        step(1, 4'd8, 1, 0, 0, 0, "R8");
        step(0, 4'd0, 1, 1, 0, 0, "R8");
        step(0, 4'd0, 1, 1, 0, 0, "R8");
        step(1, 4'd0, 1, 1, 0, 0, "R8");
        step(1, 4'd0, 1, 1, 0, 0, "R8");
        // R5 five equal is legal, sixth is a stuff error
        step(1, 4'd1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(1, 4'd2, 0, 0, 0, 0, "R5");
        step(1, 4'd2, 1, 1, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(1, 4'd3, 1, 1, 0, 0, "R5");
        step(1, 4'd5, 1, 1, 0, 0, "R5");
        step(1, 4'd4, 1, 1, 0, 0, "R5");
        step(1, 4'd4, 1, 1, 0, 0, "R5");
        // R5 start-of-frame restarts the run
        step(1, 4'd1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 3; i++) step(1, 4'd2, 0, 0, 0, 0, "R5");
        step(1, 4'd1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(1, 4'd2, 0, 0, 0, 0, "R5");
        // R9 unused codes raise nothing
        step(1, 4'd12, 0, 1, 1, 0, "R9");

        for (int n = 0; n < 4000; n++) begin
            logic [3:0] f;
            logic r, t;
            f = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(1, 9));
            r = ($urandom_range(0, 3) != 0) ? rx_bit : 1'($urandom_range(0, 1));
            t = ($urandom_range(0, 3) != 0) ? r : 1'($urandom_range(0, 1));
            step(1'($urandom_range(0, 3) != 0), f, t, r, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), "rand");
        end

        summary();
        $finish;
    end
endmodule